// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address. It reads one or two 32-bit descriptors from memory. A translation request gives the virtual address and the base of the first-level table. The walker then issues word reads on a memory port that allows one read at a time. Each descriptor it gets back has a present bit and a 2-bit type code. The walker decodes these to decide whether to stop with a mapping, go down one more level, or stop with a fault. For a table descriptor, the mask picked by the type code fixes two things. It gives the base of the second-level table. Its number of leading ones also gives the shift that picks which virtual-address bits index that table.

Three interfaces use valid/ready handshakes: the request, the memory read request and the result. A request is accepted only while the walker is idle (`req_ready` high). Everything else applies back-pressure as follows:
- A memory read stays asserted, with its address unchanged, until the memory takes it with `mem_rd_ready`.
- The memory response has no ready signal. The walker always accepts a response while a read is outstanding.
- The result stays asserted, unchanged, until the consumer takes it with `res_ready`. Only then does the walker accept a new request.
- After the result is taken, the result fields keep their values until the next walk writes them.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1 while `mem_rd_valid` and `res_valid` are both 0.
- R2: The first read goes to `req_base + 4 * req_va[31:22]`.
- R3: If bit 2 of a descriptor (the present bit) is 0, the walk ends with `res_fault` = 1 and `res_level` set to the level of that descriptor (1 or 2), and no further read is issued.
- R4: A present first-level descriptor with type bits [1:0] = 2 ends the walk after one read, with a fault at level 1.
- R5: A present first-level descriptor with type 3 ends the walk after one read with `res_level` = 1. The result is `res_pa = (d & 0xFFC00000) | (va & 0x003FFFFF)`.
- R6: A present first-level descriptor with type 0 causes a second read at `(d & 0xFFFFF000) + 4 * va[21:12]`. This follows from the mask's 20 leading ones.
- R7: A present first-level descriptor with type 1 causes a second read at `(d & 0xFFFFFC00) + 4 * va[21:14]`. This follows from the mask's 22 leading ones.
- R8: A present second-level descriptor selects its mask by type: 0 gives 0xFFFFF000, 1 gives 0xFFFFC000, 2 gives 0xFFFF0000. The walk ends with `res_level` = 2 and `res_pa = (d & mask) | (va & ~mask)`.
- R9: A present second-level descriptor with type 3 ends the walk with a fault at level 2.
- R10: A read request stays asserted with the same address until `mem_rd_ready` is high. No new read is issued until the response to the previous one has arrived.
- R11: `res_valid` stays high, with `res_pa`, `res_fault` and `res_level` unchanged, until `res_ready` is high. `req_ready` is high only when no walk is in progress and no result is pending.
- R12: A faulting result has `res_pa` = 0. `res_level` holds 1 or 2 while `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base, word aligned |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Translation result present |
| res_ready | input | 1 | Consumer takes the result |
| res_pa | output | 32 | Physical address, 0 on a fault |
| res_fault | output | 1 | Walk ended in a fault |
| res_level | output | 2 | Level that ended the walk (1 or 2) |

## Verification
The assertions assume the following about the inputs:
- `req_base` is word aligned.
- The memory raises `mem_rsp_valid` for exactly one cycle per accepted read.
- The memory never returns data while no read is outstanding.

The bench's memory model follows these rules. It takes a read only after the handshake, waits a random zero to two cycles, then returns a single-cycle response. Tables use only aligned bases. `mem_rd_ready` and `res_ready` are toggled at random so that both stall paths are exercised.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W        = 32;
  localparam int L1_IDX_LSB  = 22;
  localparam int PRESENT_BIT = 2;
  localparam int IDX_ADJ     = VA_W - L1_IDX_LSB;
  localparam int CLO_W       = $clog2(VA_W + 1);

  typedef enum logic [1:0] {DK_TABLE, DK_LEAF, DK_FAULT} dkind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_WT1, ST_RD2, ST_WT2, ST_DONE
  } wstate_e;

  typedef struct packed {
    dkind_e            kind;
    logic [VA_W-1:0]   mask;
  } ddec_t;
endpackage

// File: rtl/pgwalk_desc_dec.sv
module pgwalk_desc_dec
  import pgwalk_pkg::*;
#(
  parameter int LEVEL = 1
) (
  input  logic [2:0] dbits,
  output ddec_t      dec
);
  ddec_t raw;

  generate
    if (LEVEL == 1) begin : g_lvl1
      always_comb begin
        case (dbits[1:0])
          2'd0:    raw = '{kind: DK_TABLE, mask: 32'hFFFF_F000};
          2'd1:    raw = '{kind: DK_TABLE, mask: 32'hFFFF_FC00};
          2'd3:    raw = '{kind: DK_LEAF,  mask: 32'hFFC0_0000};
          default: raw = '{kind: DK_FAULT, mask: '0};
        endcase
      end
    end else begin : g_lvl2
      always_comb begin
        case (dbits[1:0])
          2'd0:    raw = '{kind: DK_LEAF,  mask: 32'hFFFF_F000};
          2'd1:    raw = '{kind: DK_LEAF,  mask: 32'hFFFF_C000};
          2'd2:    raw = '{kind: DK_LEAF,  mask: 32'hFFFF_0000};
          default: raw = '{kind: DK_FAULT, mask: '0};
        endcase
      end
    end
  endgenerate

  assign dec = dbits[PRESENT_BIT] ? raw : '{kind: DK_FAULT, mask: '0};
endmodule

// File: rtl/pgwalk_clo.sv
module pgwalk_clo #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  logic run;

  always_comb begin
    count = '0;
    run   = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      if (run && vec[i]) count = count + CW'(1);
      else               run   = 1'b0;
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic [VA_W-1:0] req_base,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [VA_W-1:0] mem_rd_addr,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [VA_W-1:0] res_pa,
  output logic            res_fault,
  output logic [1:0]      res_level
);
  wstate_e          state_q;
  logic [VA_W-1:0]  va_q, addr_q, pa_q;
  logic             fault_q;
  logic [1:0]       lvl_q;

  ddec_t            dec1, dec2;
  logic [CLO_W-1:0] ones1, sh2;
  logic [VA_W-1:0]  va_low, l1_addr, l2_addr, leaf1_pa, leaf2_pa;

  pgwalk_desc_dec #(.LEVEL(1)) u_dec1 (.dbits(mem_rsp_data[2:0]), .dec(dec1));
  pgwalk_desc_dec #(.LEVEL(2)) u_dec2 (.dbits(mem_rsp_data[2:0]), .dec(dec2));

  pgwalk_clo #(.W(VA_W), .CW(CLO_W)) u_clo (.vec(dec1.mask), .count(ones1));

  // first-level entry: base plus the top index bits scaled to words
  assign l1_addr = req_base +
                   {{(VA_W - IDX_ADJ - 2){1'b0}}, req_va[VA_W-1:L1_IDX_LSB], 2'b00};

  // second-level entry: low VA bits shifted by (leading ones - IDX_ADJ), word aligned
  assign va_low  = {{IDX_ADJ{1'b0}}, va_q[L1_IDX_LSB-1:0]};
  assign sh2     = ones1 - CLO_W'(IDX_ADJ);
  assign l2_addr = (mem_rsp_data & dec1.mask) + ((va_low >> sh2) & ~VA_W'(3));

  assign leaf1_pa = (mem_rsp_data & dec1.mask) | (va_q & ~dec1.mask);
  assign leaf2_pa = (mem_rsp_data & dec2.mask) | (va_q & ~dec2.mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      lvl_q   <= 2'd0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_va;
          addr_q  <= l1_addr;
          state_q <= ST_RD1;
        end
        ST_RD1: if (mem_rd_ready) state_q <= ST_WT1;
        ST_WT1: if (mem_rsp_valid) begin
          case (dec1.kind)
            DK_TABLE: begin
              addr_q  <= l2_addr;
              state_q <= ST_RD2;
            end
            DK_LEAF: begin
              pa_q    <= leaf1_pa;
              fault_q <= 1'b0;
              lvl_q   <= 2'd1;
              state_q <= ST_DONE;
            end
            default: begin
              pa_q    <= '0;
              fault_q <= 1'b1;
              lvl_q   <= 2'd1;
              state_q <= ST_DONE;
            end
          endcase
        end
        ST_RD2: if (mem_rd_ready) state_q <= ST_WT2;
        ST_WT2: if (mem_rsp_valid) begin
          lvl_q   <= 2'd2;
          state_q <= ST_DONE;
          if (dec2.kind == DK_LEAF) begin
            pa_q    <= leaf2_pa;
            fault_q <= 1'b0;
          end else begin
            pa_q    <= '0;
            fault_q <= 1'b1;
          end
        end
        ST_DONE: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign mem_rd_addr  = addr_q;
  assign res_valid    = (state_q == ST_DONE);
  assign res_pa       = pa_q;
  assign res_fault    = fault_q;
  assign res_level    = lvl_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_va,
  input logic [31:0] req_base,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rsp_valid,
  input logic [31:0] mem_rsp_data,
  input logic        res_valid,
  input logic        res_ready,
  input logic [31:0] res_pa,
  input logic        res_fault,
  input logic [1:0]  res_level
);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R10
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && mem_rd_ready |=> !mem_rd_valid);

  // R2
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00);

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pa) &&
                                $stable(res_fault) && $stable(res_level));

  // R11
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_rd_valid, res_valid}));

  // R12
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_pa == 32'h0);

  // R12
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_level == 2'd1 || res_level == 2'd2));
endmodule

bind pgwalk_top pgwalk_chk u_chk (.*);

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] req_base = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_pa;
  logic        res_fault;
  logic [1:0]  res_level;

  pgwalk_top uut (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] pa;
    logic        fault;
    logic [1:0]  lvl;
    int          reads;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mem_img [logic [31:0]];
  int          n_tests = 0;
  int          n_fail  = 0;
  int          reads_seen = 0;

  localparam logic [31:0] B = 32'h0010_0000;

  task automatic chk(input bit ok, input string msg,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  function automatic logic [31:0] l1a(input logic [31:0] base, input logic [31:0] va);
    return base + {20'b0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] leaf(input logic [31:0] d, input logic [31:0] m,
                                       input logic [31:0] va);
    return (d & m) | (va & ~m);
  endfunction

  // memory model: one read at a time, 0..2 cycles latency
  initial begin
    bit          pend = 0;
    logic [31:0] paddr;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rd_ready  = ($urandom % 3) != 0;
      #1;
      if (pend) begin
        chk(mem_rd_valid && mem_rd_addr == paddr, "R10 read held while stalled",
            mem_rd_addr, paddr);
        pend = 0;
      end
      if (mem_rd_valid && !mem_rd_ready) begin
        pend  = 1;
        paddr = mem_rd_addr;
      end else if (mem_rd_valid && mem_rd_ready) begin
        logic [31:0] a;
        int lat;
        a   = mem_rd_addr;
        lat = $urandom % 3;
        reads_seen++;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_img.exists(a) ? mem_img[a] : 32'h0;
      end
    end
  end

  // monitor: pops the scoreboard on each result handshake
  initial begin
    bit          hold = 0;
    logic [31:0] hpa;
    forever begin
      @(negedge clk);
      res_ready = ($urandom % 4) != 0;
      #1;
      if (hold) begin
        chk(res_valid && res_pa == hpa, "R11 result held while stalled", res_pa, hpa);
        hold = 0;
      end
      if (res_valid && !res_ready) begin
        hold = 1;
        hpa  = res_pa;
      end else if (res_valid && res_ready) begin
        if (sb.size() == 0) begin
          chk(0, "R11 unexpected result", res_pa, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(res_pa == e.pa, {e.tag, " pa"}, res_pa, e.pa);
          chk(res_fault == e.fault, {e.tag, " fault"}, 32'(res_fault), 32'(e.fault));
          chk(res_level == e.lvl, {e.tag, " level (R12)"}, 32'(res_level), 32'(e.lvl));
          chk(reads_seen == e.reads, {e.tag, " read count"}, reads_seen, e.reads);
        end
        reads_seen = 0;
      end
    end
  end

  task automatic do_walk(input logic [31:0] va, input logic [31:0] pa,
                         input logic f, input logic [1:0] lvl, input int rd,
                         input string tag);
    exp_t e;
    e = '{pa: pa, fault: f, lvl: lvl, reads: rd, tag: tag};
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = va;
    req_base  = B;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(!req_ready, "R11 busy after accept", 32'(req_ready), 32'h0);
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 32'h0, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] va, d1, d2, tbl;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'h1);
    chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid", 32'(mem_rd_valid), 32'h0);
    chk(res_valid == 1'b0, "R1 res_valid", 32'(res_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready == 1'b1 && res_valid == 1'b0, "R1 idle after release",
        32'(req_ready), 32'h1);

    // R2 R5: super page
    va = 32'h1234_5678; d1 = 32'hABC0_0007;
    mem_img[l1a(B, va)] = d1;
    do_walk(va, leaf(d1, 32'hFFC0_0000, va), 0, 2'd1, 1, "R5 super page");

    // R2 R5: top index boundary
    va = 32'hFFFF_FFFF; d1 = 32'h0040_000F;
    mem_img[l1a(B, va)] = d1;
    do_walk(va, 32'h007F_FFFF, 0, 2'd1, 1, "R2 R5 last index");

    // R3: first level not present
    va = 32'h0080_0000; d1 = 32'hABC0_0003;
    mem_img[l1a(B, va)] = d1;
    do_walk(va, 32'h0, 1, 2'd1, 1, "R3 L1 absent");

    // R4: invalid first-level type
    va = 32'h00C0_0000; d1 = 32'h0020_0006;
    mem_img[l1a(B, va)] = d1;
    do_walk(va, 32'h0, 1, 2'd1, 1, "R4 L1 type2");

    // R6 R8: small table, 4 KiB page
    va = 32'h0143_5ABC; d1 = 32'h0020_0F04; d2 = 32'h7777_7FF4;
    tbl = d1 & 32'hFFFF_F000;
    mem_img[l1a(B, va)] = d1;
    mem_img[tbl + {20'b0, va[21:12], 2'b00}] = d2;
    do_walk(va, leaf(d2, 32'hFFFF_F000, va), 0, 2'd2, 2, "R6 R8 page");

    // R8: middle page
    va = 32'h0187_9ABC; d1 = 32'h0030_0004; d2 = 32'h1234_5FF5;
    tbl = d1 & 32'hFFFF_F000;
    mem_img[l1a(B, va)] = d1;
    mem_img[tbl + {20'b0, va[21:12], 2'b00}] = d2;
    do_walk(va, leaf(d2, 32'hFFFF_C000, va), 0, 2'd2, 2, "R8 middle page");

    // R8: large page
    va = 32'h01CF_EDCB; d1 = 32'h0040_0004; d2 = 32'h9876_FFF6;
    tbl = d1 & 32'hFFFF_F000;
    mem_img[l1a(B, va)] = d1;
    mem_img[tbl + {20'b0, va[21:12], 2'b00}] = d2;
    do_walk(va, leaf(d2, 32'hFFFF_0000, va), 0, 2'd2, 2, "R8 large page");

    // R7: large table, page
    va = 32'h0205_6789; d1 = 32'h0050_0FF5; d2 = 32'h1122_3344;
    tbl = d1 & 32'hFFFF_FC00;
    mem_img[l1a(B, va)] = d1;
    mem_img[tbl + {22'b0, va[21:14], 2'b00}] = d2;
    do_walk(va, leaf(d2, 32'hFFFF_F000, va), 0, 2'd2, 2, "R7 large table");

    // R7 R8: large table, large page, top VA bits
    va = 32'h023F_FFFF; d1 = 32'h0060_0005; d2 = 32'hCAFE_0006;
    tbl = d1 & 32'hFFFF_FC00;
    mem_img[l1a(B, va)] = d1;
    mem_img[tbl + {22'b0, va[21:14], 2'b00}] = d2;
    do_walk(va, leaf(d2, 32'hFFFF_0000, va), 0, 2'd2, 2, "R7 R8 large/large");

    // R3 R12: second level not present
    va = 32'h0280_1000; d1 = 32'h0070_0004; d2 = 32'hFFFF_F000;
    tbl = d1 & 32'hFFFF_F000;
    mem_img[l1a(B, va)] = d1;
    mem_img[tbl + {20'b0, va[21:12], 2'b00}] = d2;
    do_walk(va, 32'h0, 1, 2'd2, 2, "R3 R12 L2 absent");

    // R9: invalid second-level type
    va = 32'h02C0_2000; d1 = 32'h0080_0004; d2 = 32'h1234_5007;
    tbl = d1 & 32'hFFFF_F000;
    mem_img[l1a(B, va)] = d1;
    mem_img[tbl + {20'b0, va[21:12], 2'b00}] = d2;
    do_walk(va, 32'h0, 1, 2'd2, 2, "R9 L2 type3");

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule